// File: doc/BRIEF.md
# System Reset Control Port

This block is a single byte-wide register that sits at one fixed I/O port address. Software writes it to ask for a reset of the whole system. Software reads it to see which reset type was last selected. The block decodes one-byte I/O reads and writes. It answers only at its own address. When a write carries the trigger bit, it sends a single-clock request to the system reset controller.

The written byte does two separate jobs. Bit 2 fires the request and is never stored. Bit 1, the reset-type selection, is the only bit the register keeps; every other stored bit is forced to zero on each write. Carrying out the reset, and telling one reset type from another, belong to the controller downstream.

The reset input is asynchronous and active low. Its release is synchronised through a two-stage chain, so the port answers from the third rising edge after `rst_n` goes high.

Top module: `rstctl_sysreset`

## Requirements
- R1: The port answers only at I/O address 0xCF9. `io_ack` is high in a cycle exactly when the address is 0xCF9, `io_rd` or `io_wr` is high, and the block is out of reset.
- R2: An accepted write with bit 2 of `io_wdata` set drives `sys_rst_req` high for exactly the one clock cycle that follows the write.
- R3: An accepted write stores only bit 1 of `io_wdata`. Stored bits 7..2 and bit 0 become zero, so the trigger bit is never kept.
- R4: A read at 0xCF9 returns the stored byte on `io_rdata` in the same cycle. In every cycle without an accepted read, `io_rdata` is 0x00.
- R5: While reset is active, and on the first cycle it is released, the stored byte is 0x00, `sys_rst_req` is low and `io_ack` is low. This holds for a reset applied at power-on and for one applied mid-run.
- R6: Reads have no side effects. They never raise `sys_rst_req` and never change the stored byte.
- R7: A write to any address other than 0xCF9 is ignored. It gives no `io_ack`, raises no `sys_rst_req` and leaves the stored byte unchanged.
- R8: An accepted write with bit 2 clear raises no `sys_rst_req`.
- R9: Trigger writes in consecutive cycles each give their own request, so `sys_rst_req` stays high for one cycle per write.
- R10: When a read and a write hit 0xCF9 in the same cycle, the read returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| io_addr | input | 16 | I/O port address of the current access |
| io_rd | input | 1 | One-byte read strobe |
| io_wr | input | 1 | One-byte write strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data, 0x00 unless a read hits the port |
| io_ack | output | 1 | Access accepted by this port |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A corrupted stored byte cannot hide for long. The very next read at 0xCF9 shows it on `io_rdata`, since the bench reads the port after every write pattern. A faulty request path shows up one cycle after the write that caused it. It appears either as a missing pulse, or as a high `sys_rst_req` with no trigger write before it: after a read, after a write with bit 2 clear, or after a write to a neighbouring address. A wrong reset-release delay shows at the ports as an `io_ack` one cycle too early or too late after `rst_n` rises.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  // Decoded access for one cycle
  typedef struct packed {
    logic rd_hit;
    logic wr_hit;
  } acc_t;

endpackage

// File: rtl/rstctl_rst_sync.sv
module rstctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/rstctl_decode.sv
module rstctl_decode
  import rstctl_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              live,
  output acc_t              acc
);

  logic match;

  always_comb begin
    match      = live && (io_addr == PORT_ADDR);
    acc.rd_hit = match && io_rd;
    acc.wr_hit = match && io_wr;
  end

endmodule

// File: rtl/rstctl_store.sv
module rstctl_store #(
  parameter int DATA_W   = 8,
  parameter int KEEP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << KEEP_BIT;

  logic [DATA_W-1:0] d;

  always_comb begin
    d = q;
    if (wr_en) begin
      d = wdata & KEEP_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q <= d;
    end
  end

  // R3: the byte held after a write is the masked write data
  a_r3_masked_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == ($past(wdata) & KEEP_MASK)));

  // R6 / R7: no write, no change
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/rstctl_pulse.sv
module rstctl_pulse #(
  parameter int DATA_W   = 8,
  parameter int TRIG_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              req
);

  logic req_d;

  always_comb begin
    req_d = wr_en && wdata[TRIG_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
    end else begin
      req <= req_d;
    end
  end

endmodule

// File: rtl/rstctl_sysreset.sv
module rstctl_sysreset
  import rstctl_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int                TRIG_BIT  = 2,
  parameter int                KEEP_BIT  = 1,
  parameter int                SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_ack,
  output logic              sys_rst_req
);

  logic              rst_int_n;
  acc_t              acc;
  logic [DATA_W-1:0] store_q;

  rstctl_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  rstctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .live    (rst_int_n),
    .acc     (acc)
  );

  rstctl_store #(.DATA_W(DATA_W), .KEEP_BIT(KEEP_BIT)) u_store (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (acc.wr_hit),
    .wdata (io_wdata),
    .q     (store_q)
  );

  rstctl_pulse #(.DATA_W(DATA_W), .TRIG_BIT(TRIG_BIT)) u_pulse (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (acc.wr_hit),
    .wdata (io_wdata),
    .req   (sys_rst_req)
  );

  always_comb begin
    io_ack   = acc.rd_hit || acc.wr_hit;
    io_rdata = acc.rd_hit ? store_q : '0;
  end

  // R1: an acknowledged access carries the port address
  a_r1_ack_on_port: assert property (@(posedge clk) disable iff (!rst_int_n)
    io_ack |-> (io_addr == PORT_ADDR));

  // R2: trigger write at the port gives a request next cycle
  a_r2_req_after_trigger: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_wr && io_addr == PORT_ADDR && io_wdata[TRIG_BIT]) |=> sys_rst_req);

  // R8 / R6 / R7: every request has a trigger write at the port before it
  a_r8_req_has_cause: assert property (@(posedge clk) disable iff (!rst_int_n)
    sys_rst_req |-> $past(io_wr && io_addr == PORT_ADDR && io_wdata[TRIG_BIT]));

  // R4: no accepted read, no data
  a_r4_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !io_ack |-> (io_rdata == '0));

  // R5: clean state on release of reset
  a_r5_clean_release: assert property (@(posedge clk)
    $rose(rst_int_n) |-> (store_q == '0 && !sys_rst_req));

endmodule

// File: tb/rstctl_sysreset_test.sv
module rstctl_sysreset_test;

  localparam logic [15:0] PORT = 16'hCF9;

  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_rd;
  logic        io_wr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        io_ack;
  logic        sys_rst_req;

  int n_cmp;
  int n_bad;
  int cycles;
  int live_cnt;
  bit [7:0] m_store;
  bit       m_pulse;

  rstctl_sysreset uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .io_ack      (io_ack),
    .sys_rst_req (sys_rst_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: reset release after two edges, one byte of state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cnt = 0;
      m_store  = 8'h00;
      m_pulse  = 1'b0;
    end else begin
      if (live_cnt >= 2) begin
        m_pulse = io_wr && (io_addr == PORT) && io_wdata[2];
        if (io_wr && io_addr == PORT) m_store = io_wdata & 8'h02;
      end else begin
        m_pulse = 1'b0;
        m_store = 8'h00;
      end
      if (live_cnt < 2) live_cnt++;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    bit live;
    bit hit;
    live = rst_n && (live_cnt >= 2);
    hit  = live && (io_addr == PORT);
    check("R1 ack", int'(io_ack), int'(hit && (io_rd || io_wr)));
    check("R4 rdata", int'(io_rdata), (hit && io_rd) ? int'(m_store) : 0);
    check("R2 req", int'(sys_rst_req), int'(m_pulse));
  end

  task automatic idle();
    io_addr = 16'h0000; io_rd = 1'b0; io_wr = 1'b0; io_wdata = 8'h00;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d,
                    input bit exp_req, input string tag);
    @(negedge clk); #1;
    io_addr = a; io_wr = 1'b1; io_wdata = d;
    @(negedge clk);
    check(tag, int'(sys_rst_req), int'(exp_req));
    #1 idle();
  endtask

  task automatic rd(input logic [15:0] a, input bit exp_ack,
                    input logic [7:0] exp_d, input string tag);
    @(negedge clk); #1;
    io_addr = a; io_rd = 1'b1;
    #5;
    check({tag, " ack"}, int'(io_ack), int'(exp_ack));
    check({tag, " data"}, int'(io_rdata), int'(exp_d));
    @(negedge clk);
    check({tag, " no req"}, int'(sys_rst_req), 0);
    #1 idle();
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R5: quiet while held in reset
    io_addr = PORT; io_rd = 1'b1; #2;
    check("R5 ack in reset", int'(io_ack), 0);
    idle();
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(PORT, 1, 8'h00, "R5 power-on value");

    wr(PORT, 8'h06, 1, "R2 trigger pulse");
    check("R2 single cycle", int'(sys_rst_req), 1);
    @(negedge clk);
    check("R2 pulse ends", int'(sys_rst_req), 0);
    rd(PORT, 1, 8'h02, "R3 type bit kept");

    wr(PORT, 8'h04, 1, "R2 trigger only");
    rd(PORT, 1, 8'h00, "R3 trigger not stored");
    wr(PORT, 8'hFB, 0, "R8 no trigger");
    rd(PORT, 1, 8'h02, "R3 mask on FB");
    wr(PORT, 8'hFD, 1, "R2 trigger FD");
    rd(PORT, 1, 8'h00, "R3 mask on FD");

    wr(PORT, 8'h02, 0, "R8 type only");
    wr(16'hCF8, 8'hFF, 0, "R7 write CF8");
    wr(16'hCFA, 8'h04, 0, "R7 write CFA");
    wr(16'h0CF9 ^ 16'h8000, 8'h04, 0, "R7 write far");
    rd(16'hCF8, 0, 8'h00, "R1 read CF8");
    rd(PORT, 1, 8'h02, "R7 value kept");

    for (int i = 0; i < 4; i++) rd(PORT, 1, 8'h02, "R6 repeated read");

    // R9: back-to-back trigger writes
    @(negedge clk); #1;
    io_addr = PORT; io_wr = 1'b1; io_wdata = 8'h04;
    @(negedge clk);
    check("R9 first pulse", int'(sys_rst_req), 1);
    #1 io_wdata = 8'h06;
    @(negedge clk);
    check("R9 second pulse", int'(sys_rst_req), 1);
    #1 idle();
    @(negedge clk);
    check("R9 pulses end", int'(sys_rst_req), 0);

    // R10: read and write together return the old byte
    @(negedge clk); #1;
    io_addr = PORT; io_rd = 1'b1; io_wr = 1'b1; io_wdata = 8'h00;
    #5 check("R10 old value on read", int'(io_rdata), 8'h02);
    @(negedge clk); #1 idle();
    rd(PORT, 1, 8'h00, "R10 new value after");

    // R5: reset in mid-run clears the stored byte
    wr(PORT, 8'h02, 0, "R8 reload");
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    check("R5 req in reset", int'(sys_rst_req), 0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(PORT, 1, 8'h00, "R5 cleared mid-run");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule